// File: doc/BRIEF.md
# Double-Buffered 8-bit PWM Generator

This block produces a pulse-width-modulated waveform from an 8-bit up-counter that runs from 0 up to a programmable period value and then wraps to 0. The counter advances on a prescaled tick, which is the system clock divided by 1, 2, 4 or 8. The output is high while a working duty buffer is greater than or equal to the counter. The duty input is double-buffered: the buffer picks up a new duty value only at a period boundary, so a change in the middle of a period never produces a runt pulse.

At every period boundary a sticky completion flag is set. The flag is cleared by an acknowledge strobe and raises an interrupt request only while the interrupt enable is set. A hold-clear control keeps the counter and the prescaler at zero and loads the duty value straight into the buffer on every cycle. Counting resumes, with a full-length first period, once hold-clear drops. A pin multiplexer routes either the PWM waveform or a general-purpose output value to the pin.

All controls are plain level inputs that a register file outside the block drives. The block carries no data stream, so it has no valid/ready handshake.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While the block is in reset, and right after reset, the counter and duty buffer are 0, so pwm_o is 1, irq_flag_o is 0 and irq_o is 0.
- R2: The prescaler select picks the tick spacing: 0 gives one tick per clock, 1 one tick per 2 clocks, 2 one tick per 4 clocks and 3 one tick per 8 clocks.
- R3: The counter steps by one on each tick. On the tick where it equals period_i it returns to 0, so one period lasts (period_i+1) ticks.
- R4: A change on duty_i reaches the output only after the tick on which the counter wraps. Until then pwm_o follows the duty value captured at the previous wrap or during hold-clear.
- R5: pwm_o is 1 exactly when the buffered duty is greater than or equal to the counter. A duty of 0 therefore gives one high count per period.
- R6: irq_flag_o becomes 1 on the clock after a wrap tick and stays 1 until irq_ack_i is seen. If a wrap and an acknowledge fall in the same cycle, the flag is set.
- R7: irq_o equals irq_flag_o AND irq_en_i.
- R8: While hold_clr_i is 1, the counter and prescaler stay at 0, the buffer is loaded from duty_i on each clock and no wrap sets the flag. After release, the first tick comes after a full 2^sel clocks.
- R9: pin_o carries pwm_o when out_en_i is 1 and gpio_i when out_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | 8 | Requested duty value, taken into the buffer at a wrap or during hold-clear |
| period_i | input | 8 | Counter top value; the period is period_i+1 ticks |
| psc_sel_i | input | 2 | Prescaler select: 0 /1, 1 /2, 2 /4, 3 /8 |
| hold_clr_i | input | 1 | Holds the counter and prescaler at zero and loads the duty buffer |
| out_en_i | input | 1 | 1 routes the PWM to the pin, 0 routes gpio_i |
| gpio_i | input | 1 | General-purpose pin value used when out_en_i is 0 |
| irq_en_i | input | 1 | Interrupt request enable |
| irq_ack_i | input | 1 | Clears the completion flag |
| pwm_o | output | 1 | PWM waveform |
| pin_o | output | 1 | Pin output after the multiplexer |
| irq_flag_o | output | 1 | Sticky period-complete flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench changes the duty in the middle of a period and checks that the old duty still decides the output at a later count of the same period. A design without the double buffer would switch level early. It measures the clocks between two completion flags, and from hold-clear release to the first flag, for several prescaler settings. A design that leaves the prescaler running through hold-clear, or that wraps one count early or late, gives the wrong spacing. It also holds the acknowledge high across wraps, where a design that favoured the clear would never show the flag, and it checks that a zero duty still gives one high count per period.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int CNT_W_DEF = 8;
  localparam int SEL_W_DEF = 2;

  typedef enum logic [1:0] {
    PSC_DIV1 = 2'd0,
    PSC_DIV2 = 2'd1,
    PSC_DIV4 = 2'd2,
    PSC_DIV8 = 2'd3
  } psc_sel_e;

  function automatic int psc_cnt_width(input int sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/pwm_dbuf_prescaler.sv
module pwm_dbuf_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             hold_clr_i,
  output logic             tick_o
);
  localparam int PW = pwm_dbuf_pkg::psc_cnt_width(SEL_W);

  logic [PW-1:0] div_cnt;
  logic [PW-1:0] limit;

  // limit = 2^sel - 1, built as a thermometer mask
  for (genvar g = 0; g < PW; g++) begin : g_mask
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign limit[g] = (IDX < psc_sel_i);
  end

  assign tick_o = !hold_clr_i && (div_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_cnt <= '0;
    else if (hold_clr_i) div_cnt <= '0;
    else if (tick_o)     div_cnt <= '0;
    else                 div_cnt <= div_cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && psc_sel_i != '0) |=> (!tick_o || psc_sel_i == '0)); // R2
  AST_NO_TICK_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |-> !tick_o); // R8
endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_clr_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] duty_buf_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] buf_q;

  assign wrap_o = tick_i && (cnt_q == period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (hold_clr_i) cnt_q <= '0;
    else if (wrap_o)     cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    buf_q <= '0;
    else if (hold_clr_i || wrap_o) buf_q <= duty_i;
  end

  assign cnt_o      = cnt_q;
  assign duty_buf_o = buf_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !hold_clr_i) |=> (cnt_o == '0)); // R3
  AST_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |=> (cnt_o == '0 && duty_buf_o == $past(duty_i))); // R8
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr_i && !wrap_o) |=> $stable(duty_buf_o)); // R4
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_clr_i && !tick_i) |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/pwm_dbuf_irq.sv
module pwm_dbuf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !ack_i) |=> flag_o); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_i && flag_o)); // R7
endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             hold_clr_i,
  input  logic             out_en_i,
  input  logic             gpio_i,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  output logic             pwm_o,
  output logic             pin_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_buf;

  pwm_dbuf_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .psc_sel_i(psc_sel_i),
    .hold_clr_i(hold_clr_i), .tick_o(tick)
  );

  pwm_dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_clr_i(hold_clr_i),
    .duty_i(duty_i), .period_i(period_i), .cnt_o(cnt),
    .duty_buf_o(duty_buf), .wrap_o(wrap)
  );

  pwm_dbuf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(wrap), .ack_i(irq_ack_i),
    .en_i(irq_en_i), .flag_o(irq_flag_o), .irq_o(irq_o)
  );

  assign pwm_o = (duty_buf >= cnt);
  assign pin_o = out_en_i ? pwm_o : gpio_i;

  AST_PIN_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |-> (pin_o == gpio_i)); // R9
  AST_NO_FLAG_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_clr_i && !irq_flag_o) |=> !irq_flag_o); // R8
endmodule

// File: tb/pwm_dbuf_gen_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] duty_i = 8'd0, period_i = 8'd0;
  logic [1:0] psc_sel_i = 2'd0;
  logic hold_clr_i = 1'b1, out_en_i = 1'b1, gpio_i = 1'b0;
  logic irq_en_i = 1'b1, irq_ack_i = 1'b0;
  logic pwm_o, pin_o, irq_flag_o, irq_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  // reference model state
  int m_psc = 0, m_cnt = 0, m_buf = 0, m_flag = 0;

  always #10 clk = ~clk;

  pwm_dbuf_gen u_pwm_dbuf_gen (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .period_i(period_i),
    .psc_sel_i(psc_sel_i), .hold_clr_i(hold_clr_i), .out_en_i(out_en_i),
    .gpio_i(gpio_i), .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i),
    .pwm_o(pwm_o), .pin_o(pin_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_psc = 0; m_cnt = 0; m_buf = 0; m_flag = 0;
    end else begin
      bit evt;
      evt = 0;
      cyc++;
      if (hold_clr_i) begin
        m_psc = 0; m_cnt = 0; m_buf = duty_i;
      end else if (m_psc + 1 >= (1 << psc_sel_i)) begin
        m_psc = 0;
        if (m_cnt == period_i) begin m_cnt = 0; m_buf = duty_i; evt = 1; end
        else m_cnt = (m_cnt + 1) % 256;
      end else m_psc++;
      if (evt) m_flag = 1;
      else if (irq_ack_i) m_flag = 0;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int ep;
      ep = (m_buf >= m_cnt) ? 1 : 0;
      chk(pwm_o == ep, "R5 pwm_o", pwm_o, ep);
      chk(pin_o == (out_en_i ? ep : gpio_i), "R9 pin_o", pin_o, out_en_i ? ep : gpio_i);
      chk(irq_flag_o == m_flag, "R6 irq_flag_o", irq_flag_o, m_flag);
      chk(irq_o == (m_flag & irq_en_i), "R7 irq_o", irq_o, m_flag & irq_en_i);
    end
  end

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (m_cnt == v) return;
    end
  endtask

  task automatic restart(input int sel, input int per, input int dty);
    @(negedge clk);
    hold_clr_i = 1; psc_sel_i = 2'(sel); period_i = 8'(per); duty_i = 8'(dty);
    irq_ack_i = 1;
    @(negedge clk);
    irq_ack_i = 0;
    @(negedge clk);
    hold_clr_i = 0;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (irq_flag_o) return;
    end
  endtask

  initial begin
    int n, t0, hi, lcg;
    bit bad2;
    gpio_i = 1;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk(pwm_o == 1, "R1 pwm_o in reset", pwm_o, 1);
    chk(irq_flag_o == 0, "R1 irq_flag_o in reset", irq_flag_o, 0);
    chk(irq_o == 0, "R1 irq_o in reset", irq_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pwm_o == 1 && irq_flag_o == 0, "R1 after reset", {pwm_o, irq_flag_o}, 2);

    // R4: mid-period duty change is deferred
    restart(0, 7, 2);
    out_en_i = 1; irq_en_i = 1;
    wait_cnt(1);
    duty_i = 8'd6;
    wait_cnt(4);
    chk(pwm_o == 0, "R4 old duty still used", pwm_o, 0);
    wait_cnt(0);
    wait_cnt(4);
    chk(pwm_o == 1, "R4 new duty after wrap", pwm_o, 1);

    // R3 / R2: spacing of completion flags, period 4 at /2 = 10 clocks
    restart(1, 4, 2);
    wait_flag(n);
    t0 = cyc;
    @(negedge clk); irq_ack_i = 1;
    @(negedge clk); irq_ack_i = 0;
    wait_flag(n);
    chk(cyc - t0 == 10, "R3 period length sel=1 per=4", cyc - t0, 10);
    restart(2, 2, 1);
    wait_flag(n);
    t0 = cyc;
    @(negedge clk); irq_ack_i = 1;
    @(negedge clk); irq_ack_i = 0;
    wait_flag(n);
    chk(cyc - t0 == 12, "R2 period length sel=2 per=2", cyc - t0, 12);

    // R5: zero duty gives one high count per period
    restart(0, 9, 0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
    chk(hi == 2, "R5 duty 0 high counts in 20 clocks", hi, 2);

    // R8: hold-clear holds, loads, sets no flag; full first period at /8
    @(negedge clk);
    hold_clr_i = 1; irq_ack_i = 1;
    @(negedge clk);
    irq_ack_i = 0; duty_i = 8'h33; psc_sel_i = 2'd3; period_i = 8'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(irq_flag_o == 0, "R8 no flag while held", irq_flag_o, 0);
      chk(pwm_o == 1, "R8 counter held at zero", pwm_o, 1);
    end
    hold_clr_i = 0;
    wait_flag(n);
    chk(n == 8, "R8 first flag after release at /8", n, 8);

    // R6: acknowledge held high, set still wins
    restart(0, 3, 1);
    irq_ack_i = 1;
    hi = 0; bad2 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_flag_o) begin
        if (hi > 0 && i == t0 + 1) bad2 = 1;
        hi++; t0 = i;
      end
    end
    irq_ack_i = 0;
    chk(hi == 10, "R6 set beats ack, flags seen", hi, 10);
    chk(!bad2, "R6 flag cleared by held ack", bad2, 0);

    // R7 / R9: gating and pin mux
    irq_en_i = 0;
    wait_flag(n);
    chk(irq_o == 0 && irq_flag_o == 1, "R7 irq masked", irq_o, 0);
    irq_en_i = 1;
    @(negedge clk);
    chk(irq_o == 1, "R7 irq enabled", irq_o, 1);
    out_en_i = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      gpio_i = ~gpio_i;
      #1 chk(pin_o == gpio_i, "R9 pin follows gpio", pin_o, gpio_i);
    end
    out_en_i = 1;

    // mixed traffic, compared every clock by the model
    lcg = 12345;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lcg = lcg * 1103515245 + 12345;
      case ((lcg >>> 16) & 15)
        0: duty_i = 8'((lcg >>> 4) & 15);
        1: period_i = 8'((lcg >>> 8) & 15);
        2: psc_sel_i = 2'((lcg >>> 3) & 3);
        3: hold_clr_i = ~hold_clr_i;
        4: irq_ack_i = 1;
        5: out_en_i = ~out_en_i;
        6: irq_en_i = ~irq_en_i;
        default: begin irq_ack_i = 0; hold_clr_i = 0; gpio_i = lcg[20]; end
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule